// File: doc/BRIEF.md
# Accumulator Execution Unit with Status Flags

This block is a clocked 8-bit execution unit that keeps an accumulator, two index registers (X and Y), a stack pointer and an 8-bit status register. Each cycle in which the valid strobe is high, it performs one operation chosen by a 3-bit operation code, using an 8-bit operand input. The operations are add with carry, subtract with borrow, load accumulator, copy accumulator to X, and increment X. The unit updates the carry, zero, overflow and negative flags to match.

All registers are visible on output ports at all times, so a surrounding sequencer or test harness can watch the architectural state directly. Subtraction goes through the same adder as addition. The operand is inverted and the current carry acts as the "no borrow" input. Signed overflow is derived from the sign bits of the accumulator, the effective operand and the result.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the first few edges after release do no work. Decimal arithmetic, stack traffic and interrupts are not handled.

Top module: `accu_core`

## Requirements
- R1: With op code 0 (add with carry), A becomes the low 8 bits of A + operand + C, and C becomes bit 8 of that 9-bit sum.
- R2: With op code 1 (subtract with borrow), A becomes the low 8 bits of A + (bitwise NOT operand) + C, and C becomes bit 8 of that sum, so C=1 after the operation means no borrow occurred.
- R3: For op codes 0 and 1, V (status bit 6) is set exactly when A before the update and the effective operand (the operand for op 0, its inverse for op 1) share a sign bit and the result's sign bit differs from it; otherwise V is cleared.
- R4: For all five operations, Z (status bit 1) is set exactly when the destination register becomes zero, and N (status bit 7) takes bit 7 of the destination.
- R5: Op code 2 loads the operand into A, and op code 3 copies A into X. Both leave C (bit 0) and V (bit 6) unchanged.
- R6: Op code 4 adds one to X, wrapping from 0xFF to 0x00, and leaves C and V unchanged.
- R7: While reset is applied, A=X=Y=0x00, the stack pointer is 0xFD and status is 0x20. The status bits from bit 0 upward are carry, zero, interrupt disable, decimal, break, unused (always one), overflow, negative.
- R8: When the valid strobe is low, or the op code is 5, 6 or 7, no register or flag changes on that edge.
- R9: Y and the stack pointer never change after reset. Status bits 2, 3 and 4 stay 0 and bit 5 stays 1.
- R10: Operations presented on the first two rising clock edges after reset is released are ignored, and all registers keep their reset values through those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| op_valid | input | 1 | Execute the presented operation on this edge |
| op_code | input | 3 | Operation select (0 add, 1 subtract, 2 load A, 3 A to X, 4 increment X) |
| operand | input | 8 | Operand value |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status flags |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, a stack pointer reset value of 0xFD and a two-stage reset synchroniser. With 8 bits the full carry and overflow space is small, so random operands together with a random carry state reach every sign combination, carry out of 0xFF and the wrap of X within a few hundred operations. The two-stage synchroniser places the ignored-operation window on exactly the first two edges after release, and a directed sequence probes that window.

// File: rtl/accu_pkg.sv
package accu_pkg;

  // operation codes on op_code
  localparam logic [2:0] OP_ADC = 3'd0;
  localparam logic [2:0] OP_SBC = 3'd1;
  localparam logic [2:0] OP_LDA = 3'd2;
  localparam logic [2:0] OP_TAX = 3'd3;
  localparam logic [2:0] OP_INX = 3'd4;

  // status bit positions
  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_I = 2;
  localparam int ST_D = 3;
  localparam int ST_B = 4;
  localparam int ST_U = 5;
  localparam int ST_V = 6;
  localparam int ST_N = 7;

  localparam logic [7:0] STATUS_RESET = 8'h20;

endpackage

// File: rtl/accu_addsub.sv
module accu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] m_eff;
  logic [W:0]   wide;

  always_comb begin
    m_eff  = sub_i ? ~m_i : m_i;
    wide   = {1'b0, a_i} + {1'b0, m_eff} + {{W{1'b0}}, cin_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    // same input signs, result sign differs
    ovf_o  = ~(a_i[MSB] ^ m_eff[MSB]) & (a_i[MSB] ^ wide[MSB]);
  end
endmodule

// File: rtl/accu_nz.sv
module accu_nz #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o,
  output logic         neg_o
);
  always_comb begin
    zero_o = (val_i == '0);
    neg_o  = val_i[W-1];
  end
endmodule

// File: rtl/accu_next.sv
module accu_next
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] acc_q,
  input  logic [W-1:0] x_q,
  input  logic [7:0]   st_q,
  output logic         acc_en,
  output logic         x_en,
  output logic         st_en,
  output logic [W-1:0] acc_d,
  output logic [W-1:0] x_d,
  output logic [7:0]   st_d
);
  localparam int NZ_SRC = 2;  // 0: accumulator result, 1: X result

  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic [W-1:0] nz_val [NZ_SRC];
  logic         nz_z   [NZ_SRC];
  logic         nz_n   [NZ_SRC];

  accu_addsub #(.W(W)) u_addsub (
    .a_i    (acc_q),
    .m_i    (operand),
    .cin_i  (st_q[ST_C]),
    .sub_i  (op_code == OP_SBC),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  always_comb begin
    nz_val[0] = acc_d;
    nz_val[1] = x_d;
  end

  for (genvar g = 0; g < NZ_SRC; g++) begin : g_nz
    accu_nz #(.W(W)) u_nz (
      .val_i  (nz_val[g]),
      .zero_o (nz_z[g]),
      .neg_o  (nz_n[g])
    );
  end

  always_comb begin
    acc_en = 1'b0;
    x_en   = 1'b0;
    st_en  = 1'b0;
    acc_d  = acc_q;
    x_d    = x_q;
    st_d   = st_q;
    if (op_valid) begin
      case (op_code)
        OP_ADC, OP_SBC: begin
          acc_en = 1'b1;
          st_en  = 1'b1;
          acc_d  = add_sum;
        end
        OP_LDA: begin
          acc_en = 1'b1;
          st_en  = 1'b1;
          acc_d  = operand;
        end
        OP_TAX: begin
          x_en  = 1'b1;
          st_en = 1'b1;
          x_d   = acc_q;
        end
        OP_INX: begin
          x_en  = 1'b1;
          st_en = 1'b1;
          x_d   = x_q + {{(W-1){1'b0}}, 1'b1};
        end
        default: ;
      endcase
    end
    if (op_valid && (op_code == OP_ADC || op_code == OP_SBC)) begin
      st_d[ST_C] = add_cout;
      st_d[ST_V] = add_ovf;
    end
    if (acc_en) begin
      st_d[ST_Z] = nz_z[0];
      st_d[ST_N] = nz_n[0];
    end else if (x_en) begin
      st_d[ST_Z] = nz_z[1];
      st_d[ST_N] = nz_n[1];
    end
  end
endmodule

// File: rtl/accu_state.sv
module accu_state
  import accu_pkg::*;
#(
  parameter int         W        = 8,
  parameter logic [7:0] SP_RESET = 8'hFD
) (
  input  logic         clk,
  input  logic         run_n,
  input  logic         acc_en,
  input  logic         x_en,
  input  logic         st_en,
  input  logic [W-1:0] acc_d,
  input  logic [W-1:0] x_d,
  input  logic [7:0]   st_d,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [7:0]   sp_q,
  output logic [7:0]   st_q
);
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      x_q <= '0;
    end else if (x_en) begin
      x_q <= x_d;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      st_q <= STATUS_RESET;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  // Y and stack pointer have no writer in this operation set
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      y_q  <= '0;
      sp_q <= SP_RESET;
    end
  end
endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int         W           = 8,
  parameter logic [7:0] SP_RESET    = 8'hFD,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [7:0]   sp_o,
  output logic [7:0]   status_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   run_n;

  // asynchronous assert, synchronous release
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign run_n = sync_q[SYNC_STAGES-1];

  logic         acc_en, x_en, st_en;
  logic [W-1:0] acc_d, x_d;
  logic [7:0]   st_d;

  accu_next #(.W(W)) u_next (
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_q    (acc_o),
    .x_q      (x_o),
    .st_q     (status_o),
    .acc_en   (acc_en),
    .x_en     (x_en),
    .st_en    (st_en),
    .acc_d    (acc_d),
    .x_d      (x_d),
    .st_d     (st_d)
  );

  accu_state #(.W(W), .SP_RESET(SP_RESET)) u_state (
    .clk    (clk),
    .run_n  (run_n),
    .acc_en (acc_en),
    .x_en   (x_en),
    .st_en  (st_en),
    .acc_d  (acc_d),
    .x_d    (x_d),
    .st_d   (st_d),
    .acc_q  (acc_o),
    .x_q    (x_o),
    .y_q    (y_o),
    .sp_q   (sp_o),
    .st_q   (status_o)
  );
endmodule

// File: rtl/accu_chk.sv
module accu_chk
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         run_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic [W-1:0] operand,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] x_o,
  input logic [W-1:0] y_o,
  input logic [7:0]   sp_o,
  input logic [7:0]   status_o
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!run_n)
    status_o[ST_U] && !status_o[ST_I] && !status_o[ST_D] && !status_o[ST_B]); // R9

  AST_Y_SP_STABLE: assert property (@(posedge clk) disable iff (!run_n)
    $stable(y_o) && $stable(sp_o)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!run_n)
    (!op_valid || op_code > OP_INX) |=>
      $stable(acc_o) && $stable(x_o) && $stable(status_o)); // R8

  AST_LOAD_KEEPS_CV: assert property (@(posedge clk) disable iff (!run_n)
    (op_valid && op_code == OP_LDA) |=>
      acc_o == $past(operand) && $stable(status_o[ST_C]) && $stable(status_o[ST_V])); // R5

  AST_INX_WRAP: assert property (@(posedge clk) disable iff (!run_n)
    (op_valid && op_code == OP_INX) |=>
      x_o == W'($past(x_o) + 1'b1) && $stable(status_o[ST_C])); // R6

  AST_TAX_ZERO: assert property (@(posedge clk) disable iff (!run_n)
    (op_valid && op_code == OP_TAX) |=>
      status_o[ST_Z] == (x_o == '0) && status_o[ST_N] == x_o[W-1]); // R4

  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!run_n)
    (op_valid && op_code == OP_ADC && acc_o[W-1] == operand[W-1]) |=>
      status_o[ST_V] == (acc_o[W-1] != $past(acc_o[W-1]))); // R3
endmodule

bind accu_core accu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .run_n    (run_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .operand  (operand),
  .acc_o    (acc_o),
  .x_o      (x_o),
  .y_o      (y_o),
  .sp_o     (sp_o),
  .status_o (status_o)
);

// File: tb/accu_core_bench.sv
`timescale 1ns/1ps
module accu_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] operand;
  logic [7:0] acc_o, x_o, y_o, sp_o, status_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of architectural state
  logic [7:0] m_a, m_x, m_y, m_sp, m_st;

  always #2 clk = ~clk;

  accu_core u_accu_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_o    (acc_o),
    .x_o      (x_o),
    .y_o      (y_o),
    .sp_o     (sp_o),
    .status_o (status_o)
  );

  function automatic logic [7:0] nz(input logic [7:0] st, input logic [7:0] v);
    logic [7:0] r;
    r = st;
    r[1] = (v == 8'h00);
    r[7] = v[7];
    return r;
  endfunction

  task automatic model_step(input logic v, input logic [2:0] op, input logic [7:0] m);
    logic [7:0] mm;
    int sres;
    int usum;
    if (!v) return;
    case (op)
      3'd0, 3'd1: begin
        mm   = (op == 3'd1) ? ~m : m;
        usum = int'(m_a) + int'(mm) + int'(m_st[0]);
        sres = int'($signed(m_a)) + int'($signed(mm)) + int'(m_st[0]);
        m_a  = usum[7:0];
        m_st[0] = (usum > 255);
        m_st[6] = (sres > 127) || (sres < -128);
        m_st = nz(m_st, m_a);
      end
      3'd2: begin m_a = m; m_st = nz(m_st, m_a); end
      3'd3: begin m_x = m_a; m_st = nz(m_st, m_x); end
      3'd4: begin m_x = m_x + 8'd1; m_st = nz(m_st, m_x); end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual a/x/y/sp/st=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic v, input logic [2:0] op);
    if (!v || op > 3'd4) return "R8";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  // drive at negedge, sample one period later at the next negedge
  task automatic apply(input logic v, input logic [2:0] op, input logic [7:0] m);
    op_valid = v;
    op_code  = op;
    operand  = m;
    @(negedge clk);
    model_step(v, op, m);
    chk(tag_of(v, op), {acc_o, x_o, y_o, sp_o, status_o}, {m_a, m_x, m_y, m_sp, m_st});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; operand = 8'h00;
    m_a = 8'h00; m_x = 8'h00; m_y = 8'h00; m_sp = 8'hFD; m_st = 8'h20;
    repeat (3) @(negedge clk);
    chk("R7 reset", {acc_o, x_o, y_o, sp_o, status_o}, 40'h00_00_00_FD_20);

    // R10: loads on the first two edges after release are dropped
    rst_n = 1'b1; op_valid = 1'b1; op_code = 3'd2; operand = 8'h55;
    @(negedge clk);
    @(negedge clk);
    chk("R10 release window", {acc_o, x_o, y_o, sp_o, status_o}, 40'h00_00_00_FD_20);

    // directed corners, state C=0 here
    apply(1'b1, 3'd2, 8'h50);
    chk("R5 load", {acc_o, status_o}, {8'h50, 8'h20});
    apply(1'b1, 3'd0, 8'h50);
    chk("R3 signed overflow", {acc_o, status_o}, {8'hA0, 8'hE0});
    apply(1'b1, 3'd0, 8'h60);
    chk("R1 carry out and R4 zero", {acc_o, status_o}, {8'h00, 8'h23});
    apply(1'b1, 3'd1, 8'h01);
    chk("R2 borrow", {acc_o, status_o}, {8'hFF, 8'hA0});
    apply(1'b1, 3'd3, 8'h00);
    chk("R5 transfer", {x_o, status_o}, {8'hFF, 8'hA0});
    apply(1'b1, 3'd4, 8'h00);
    chk("R6 wrap", {x_o, status_o}, {8'h00, 8'h22});
    apply(1'b1, 3'd6, 8'h77);
    chk("R8 unused code", {acc_o, x_o, status_o}, {8'hFF, 8'h00, 8'h22});
    apply(1'b0, 3'd2, 8'h11);
    chk("R8 strobe low", {acc_o, status_o}, {8'hFF, 8'h22});
    apply(1'b1, 3'd2, 8'h00);
    chk("R4 load zero", {acc_o, status_o}, {8'h00, 8'h22});

    for (int i = 0; i < 600; i++) begin
      apply(($urandom_range(0, 9) != 0), 3'($urandom_range(0, 7)), 8'($urandom));
      if (i % 50 == 0)
        chk("R9 fixed state", {y_o, sp_o, status_o & 8'h3C}, {8'h00, 8'hFD, 8'h20});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule